// File: doc/BRIEF.md
# Output Voltage Window Fault Supervisor

This block supervises the output of a step-down regulator through a digitized copy of its feedback voltage. Each clock it sorts the feedback code into one of three zones around a fixed 800 mV reference: below 75 % of the reference is low, above 125 % is high, and everything between is the good window. Each zone edge has a hysteresis band, so a code that sits near a threshold does not make the zone chatter.

The responses differ by zone. A low zone asks the soft-start sequencer for a fresh start with a single-cycle request and then stays quiet until the sequencer has dropped and raised its completion flag again. A high zone sets a latch-off flag that only the power-on reset clears. While the latch is set, power-good is held low and no restart is requested. Until soft-start reports completion, every zone result is ignored.

Top module: `fb_window_supervisor`

## Requirements
- R1: While reset (`rst_n` low) is applied, `pwr_good`, `restart_req` and `latched_off` are all 0.
- R2: While `ss_done` is 0, the zone results are masked. `pwr_good`, `restart_req` and `latched_off` stay 0 for any feedback code, including codes above 1000.
- R3: With `ss_done` at 1 and the zone in the window, `pwr_good` is 1 for every code from 600 to 1000 inclusive (codes are unsigned millivolts, 1 mV per LSB).
- R4: With `ss_done` at 1, a code below 600 pulses `restart_req` high for exactly one cycle and drives `pwr_good` to 0.
- R5: After a restart request, `pwr_good` and `restart_req` stay 0 whatever the feedback does, until `ss_done` has been seen at 0 and then at 1 again.
- R6: With `ss_done` at 1, a code above 1000 sets `latched_off` and drives `pwr_good` to 0.
- R7: Once `latched_off` is set, it stays set, `pwr_good` stays 0 and no restart is issued, for any feedback and any `ss_done`, until reset.
- R8: A low zone is left only when the code reaches 605 or more. A code of 604 is still treated as low.
- R9: A high zone is left only when the code falls to 995 or less. A code of 996 is still treated as high.
- R10: With the default registered input stage, a feedback change shows up on the outputs after the third rising clock edge, and an `ss_done` change shows up after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| fb_code | input | FB_W (12) | Sampled feedback level in millivolts |
| ss_done | input | 1 | Soft-start completion flag |
| pwr_good | output | 1 | Feedback is in the good window and monitoring is active |
| restart_req | output | 1 | Single-cycle request to restart soft-start |
| latched_off | output | 1 | Sticky overvoltage shutdown flag |

## Verification
A feedback code passes through three registers before it reaches the outputs: the input capture, the zone tracker and the response stage. A change to `ss_done` passes only through the response stage. The bench drives inputs on falling edges. For a feedback stimulus, it checks on the second falling edge that the old result still holds and on the third that the new result has appeared. For `ss_done`, it checks on the next falling edge. Steady-state sweeps hold each code for one cycle. Before a sweep starts, the zone has been settled for four cycles, so every sample reflects a code that is already in the pipeline.

// File: rtl/fbws_pkg.sv
package fbws_pkg;
   typedef enum logic [1:0] {
      ZN_LOW  = 2'd0,
      ZN_MID  = 2'd1,
      ZN_HIGH = 2'd2
   } zone_e;
endpackage

// File: rtl/fbws_zone.sv
module fbws_zone
   import fbws_pkg::*;
#(
   parameter int FB_W      = 12,
   parameter int REF_MV    = 800,
   parameter int UV_PCT    = 75,
   parameter int OV_PCT    = 125,
   parameter int HYST_MV   = 5,
   parameter bit REG_INPUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [FB_W-1:0] fb_code,
   output zone_e           zone
);
   localparam int UV_MV   = REF_MV * UV_PCT / 100;
   localparam int OV_MV   = REF_MV * OV_PCT / 100;
   localparam int UV_X_MV = UV_MV + HYST_MV;
   localparam int OV_X_MV = OV_MV - HYST_MV;
   localparam logic [FB_W-1:0] UV_TRIP = UV_MV[FB_W-1:0];
   localparam logic [FB_W-1:0] OV_TRIP = OV_MV[FB_W-1:0];
   localparam logic [FB_W-1:0] UV_EXIT = UV_X_MV[FB_W-1:0];
   localparam logic [FB_W-1:0] OV_EXIT = OV_X_MV[FB_W-1:0];

   generate
      if (OV_MV >= (1 << FB_W)) begin : g_bad_width
         $error("fbws_zone: overvoltage threshold does not fit in FB_W bits");
      end
      if (UV_X_MV >= OV_X_MV) begin : g_bad_band
         $error("fbws_zone: hysteresis bands overlap");
      end
   endgenerate

   logic [FB_W-1:0] fb_q;

   generate
      if (REG_INPUT) begin : g_in_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fb_q <= '0;
            else        fb_q <= fb_code;
         end
      end else begin : g_in_wire
         assign fb_q = fb_code;
      end
   endgenerate

   zone_e zone_nx;

   always_comb begin
      zone_nx = zone;
      unique case (zone)
         ZN_LOW: begin
            if (fb_q > OV_TRIP)       zone_nx = ZN_HIGH;
            else if (fb_q >= UV_EXIT) zone_nx = ZN_MID;
         end
         ZN_MID: begin
            if (fb_q < UV_TRIP)       zone_nx = ZN_LOW;
            else if (fb_q > OV_TRIP)  zone_nx = ZN_HIGH;
         end
         ZN_HIGH: begin
            if (fb_q < UV_TRIP)       zone_nx = ZN_LOW;
            else if (fb_q <= OV_EXIT) zone_nx = ZN_MID;
         end
         default: zone_nx = ZN_LOW;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) zone <= ZN_LOW;
      else        zone <= zone_nx;
   end

   // R8
   uv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zone == ZN_LOW && fb_q < UV_EXIT) |=> zone == ZN_LOW);

   // R9
   ov_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zone == ZN_HIGH && fb_q > OV_EXIT) |=> zone == ZN_HIGH);
endmodule

// File: rtl/fbws_ctrl.sv
module fbws_ctrl
   import fbws_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  zone_e zone,
   input  logic  ss_done,
   output logic  pwr_good,
   output logic  restart_req,
   output logic  latched_off
);
   logic wait_rearm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_good    <= 1'b0;
         restart_req <= 1'b0;
         latched_off <= 1'b0;
         wait_rearm  <= 1'b0;
      end else begin
         restart_req <= 1'b0;
         pwr_good    <= 1'b0;
         if (latched_off) begin
            latched_off <= 1'b1;
         end else if (wait_rearm) begin
            if (!ss_done) wait_rearm <= 1'b0;
         end else if (ss_done) begin
            unique case (zone)
               ZN_HIGH: latched_off <= 1'b1;
               ZN_LOW: begin
                  restart_req <= 1'b1;
                  wait_rearm  <= 1'b1;
               end
               ZN_MID:  pwr_good <= 1'b1;
               default: pwr_good <= 1'b0;
            endcase
         end
      end
   end

   // R4
   restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |=> !restart_req);

   // R5
   restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |=> !pwr_good);

   // R7
   latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latched_off |=> latched_off);

   // R7
   latch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latched_off |-> (!pwr_good && !restart_req));

   // R2
   ss_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_done |=> (!pwr_good && !restart_req));

   // R3
   good_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwr_good && restart_req));
endmodule

// File: rtl/fb_window_supervisor.sv
module fb_window_supervisor
   import fbws_pkg::*;
#(
   parameter int FB_W      = 12,
   parameter int REF_MV    = 800,
   parameter int UV_PCT    = 75,
   parameter int OV_PCT    = 125,
   parameter int HYST_MV   = 5,
   parameter bit REG_INPUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [FB_W-1:0] fb_code,
   input  logic            ss_done,
   output logic            pwr_good,
   output logic            restart_req,
   output logic            latched_off
);
   zone_e zone;

   fbws_zone #(
      .FB_W      (FB_W),
      .REF_MV    (REF_MV),
      .UV_PCT    (UV_PCT),
      .OV_PCT    (OV_PCT),
      .HYST_MV   (HYST_MV),
      .REG_INPUT (REG_INPUT)
   ) u_zone (
      .clk     (clk),
      .rst_n   (rst_n),
      .fb_code (fb_code),
      .zone    (zone)
   );

   fbws_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .zone        (zone),
      .ss_done     (ss_done),
      .pwr_good    (pwr_good),
      .restart_req (restart_req),
      .latched_off (latched_off)
   );

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!latched_off || rst_n));
endmodule

// File: tb/sim_fb_window_supervisor.sv
`timescale 1ns/1ps
module sim_fb_window_supervisor;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] fb;
   logic        ss;
   logic        pg, rs, lo;
   int          n_chk  = 0;
   int          n_fail = 0;

   always #2.5 clk = ~clk;

   fb_window_supervisor u0 (
      .clk(clk), .rst_n(rst_n), .fb_code(fb), .ss_done(ss),
      .pwr_good(pg), .restart_req(rs), .latched_off(lo)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int outs();
      return {29'd0, pg, rs, lo};
   endfunction

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; fb = '0; ss = 1'b0;
      settle(3);
      // R1: outputs encoded {pg,rs,lo}
      chk(outs() == 0, "R1 reset state", outs(), 0);
      rst_n = 1'b1;

      // R2: masked sweep across the whole code range
      for (int v = 0; v < 4096; v += 41) begin
         fb = v[11:0];
         settle(1);
         chk(outs() == 0, "R2 masked", outs(), 0);
      end
      fb = 12'd800; settle(4);
      ss = 1'b1; settle(1);
      chk(pg == 1'b1, "R10 ss_done latency", pg, 1);

      // R3: window sweep, both limits included
      for (int v = 600; v <= 1000; v++) begin
         fb = v[11:0];
         settle(1);
         chk(pg == 1'b1 && rs == 1'b0, "R3 window", outs(), 4);
      end
      fb = 12'd800; settle(4);

      // R4 / R10: undervoltage restart
      fb = 12'd599; settle(2);
      chk(pg == 1'b1 && rs == 1'b0, "R10 fb not yet", outs(), 4);
      settle(1);
      chk(rs == 1'b1 && pg == 1'b0, "R4 restart", outs(), 2);
      fb = 12'd800; settle(1);
      chk(rs == 1'b0, "R4 single pulse", rs, 0);
      // R5: stays quiet until ss_done toggles
      for (int i = 0; i < 6; i++) begin
         settle(1);
         chk(pg == 1'b0 && rs == 1'b0, "R5 quiet", outs(), 0);
      end
      ss = 1'b0; settle(2);
      ss = 1'b1; settle(1);
      chk(pg == 1'b1, "R5 rearm", pg, 1);

      // R8: undervoltage hysteresis
      ss = 1'b0; fb = 12'd500; settle(4);
      fb = 12'd604; settle(4);
      ss = 1'b1; settle(1);
      chk(rs == 1'b1 && pg == 1'b0, "R8 604 still low", outs(), 2);
      ss = 1'b0; fb = 12'd605; settle(4);
      ss = 1'b1; settle(1);
      chk(pg == 1'b1 && rs == 1'b0, "R8 605 recovers", outs(), 4);

      // R9: overvoltage recovery at 995 while masked
      ss = 1'b0; fb = 12'd1001; settle(4);
      fb = 12'd995; settle(4);
      ss = 1'b1; settle(1);
      chk(pg == 1'b1 && lo == 1'b0, "R9 995 recovers", outs(), 4);

      // R6 / R10: overvoltage latch
      fb = 12'd1001; settle(2);
      chk(lo == 1'b0 && pg == 1'b1, "R10 ov not yet", outs(), 4);
      settle(1);
      chk(lo == 1'b1 && pg == 1'b0, "R6 latch", outs(), 1);

      // R7: latch holds for any input
      for (int v = 0; v < 4096; v += 53) begin
         fb = v[11:0];
         ss = ((v / 53) % 2) == 1;
         settle(1);
         chk(outs() == 1, "R7 latched", outs(), 1);
      end

      // R1 / R7: only reset clears the latch
      ss = 1'b0; rst_n = 1'b0; settle(1);
      chk(outs() == 0, "R1 R7 reset clears", outs(), 0);
      rst_n = 1'b1;

      // R9: 996 still counts as high
      fb = 12'd1001; settle(4);
      fb = 12'd996; settle(4);
      ss = 1'b1; settle(1);
      chk(lo == 1'b1 && pg == 1'b0, "R9 996 still high", outs(), 1);

      finish_run();
   end
endmodule